// File: doc/BRIEF.md
# Register-Mapped Dual-Polynomial CRC Accumulator

This block is a bus-attached CRC accumulator. Software first places a starting value in the result register. Each later write to the data register folds the written word into the running CRC in one clock edge. There is no separate start command, so the data write itself performs the update. The result can be read back on the cycle after the write.

A control register chooses between two generators. The first is a 32-bit Ethernet CRC, computed in bit-reflected form. The second is a 16-bit CCITT CRC, computed MSB-first. The same register also chooses how many low bytes of each data word take part in the calculation. The hardware never seeds itself and never applies a final inversion. Those steps belong to software.

Top module: `crc_engine`

## Requirements
- R1: After reset, reads of the data register (address 0), result register (address 1) and control register (address 2) all return 0x00000000. A read of address 3 always returns 0.
- R2: A write to address 0 stores the whole 32-bit word, and a later read of address 0 returns that word unchanged.
- R3: Each write to address 0 performs exactly one CRC update of the result register, and a read of address 1 on the next cycle returns the new value. In a cycle with no write to address 0 or 1, the result register keeps its value.
- R4: A write to address 1 loads the seed exactly as written. Updates start from the stored value and never from any built-in seed.
- R5: Control bit 0 selects the generator. A value of 0 selects the 32-bit CRC with reflected polynomial 0xEDB88320, where each byte enters least-significant bit first. A value of 1 selects the 16-bit CRC with polynomial 0x1021, where each byte enters most-significant bit first.
- R6: Control bits 2:1 select the input size. Code 00 uses bits 7:0, code 01 uses bits 15:0, and codes 10 and 11 use bits 31:0. Bytes above the selected width have no effect on the result.
- R7: In both modes the bytes of a word are consumed in the order bits 7:0, then 15:8, then 23:16, then 31:24.
- R8: In 16-bit mode, an update leaves bits 31:16 of the stored result at zero. While 16-bit mode is selected, a read of address 1 returns zero in bits 31:16.
- R9: No final XOR is applied. Take the nine ASCII bytes "123456789". With seed 0xFFFFFFFF in 32-bit mode they give 0x340BC6D9. With seed 0xFFFF in 16-bit mode they give 0x29B1.
- R10: A write to the control register leaves the stored result unchanged. The new setting takes effect from the next data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 2 | Register address: 0 data, 1 result, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The bench builds the block with its default parameters: a 32-bit data word and the standard pair of generator polynomials. With this configuration, every combination of generator bit and all four size codes, including the reserved one, can be swept against a bit-serial reference model. Each sweep uses many seeds and data words that carry junk in the unused upper bytes. Chained writes exercise mid-stream mode changes in both directions. The fixed check strings confirm the byte order and the absence of any final inversion.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam logic [1:0] ADDR_DIN = 2'd0;
  localparam logic [1:0] ADDR_RES = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_32R = 2'b11
  } size_e;

  typedef struct packed {
    size_e size;
    logic  narrow;   // 1: 16-bit generator, 0: 32-bit reflected generator
  } ctl_t;

  // One byte into the reflected 32-bit CRC, least-significant bit first.
  function automatic logic [31:0] fold_byte_refl(input logic [31:0] c,
                                                 input logic [7:0]  b,
                                                 input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  // One byte into the 16-bit CRC, most-significant bit first.
  function automatic logic [15:0] fold_byte_msb(input logic [15:0] c,
                                                input logic [7:0]  b,
                                                input logic [15:0] poly);
    logic [15:0] r;
    r = c ^ {b, 8'd0};
    for (int k = 0; k < 8; k++) begin
      r = r[15] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_size_decode.sv
module crc_size_decode
  import crc_eng_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  size_e            size,
  output logic [CNT_W-1:0] nbytes
);
  always_comb begin
    unique case (size)
      SZ_8:    nbytes = CNT_W'(1);
      SZ_16:   nbytes = CNT_W'(2);
      default: nbytes = CNT_W'(NBYTES);
    endcase
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_eng_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] POLY_WIDE   = 32'hEDB88320,
  parameter logic [15:0] POLY_NARROW = 16'h1021,
  localparam int NBYTES = DATA_W / 8,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic [31:0]       crc_in,
  input  logic [DATA_W-1:0] data,
  input  logic              narrow,
  input  logic [CNT_W-1:0]  nbytes,
  output logic [31:0]       crc_out
);
  logic [31:0] stage [NBYTES+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [7:0]  lane;
    logic [31:0] nxt;
    assign lane = data[8*i +: 8];
    assign nxt  = narrow ? {16'd0, fold_byte_msb(stage[i][15:0], lane, POLY_NARROW)}
                         : fold_byte_refl(stage[i], lane, POLY_WIDE);
    assign stage[i+1] = (CNT_W'(i) < nbytes) ? nxt : stage[i];
  end

  assign crc_out = stage[NBYTES];
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_eng_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] POLY_WIDE   = 32'hEDB88320,
  parameter logic [15:0] POLY_NARROW = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [31:0]      din_q;
  logic [31:0]      res_q;
  ctl_t             ctl_q;
  logic [CNT_W-1:0] nbytes;
  logic [31:0]      res_next;

  // Named events for the checker
  logic upd_fire, seed_fire, ctl_fire;
  assign upd_fire  = bus_wr && (bus_addr == ADDR_DIN);
  assign seed_fire = bus_wr && (bus_addr == ADDR_RES);
  assign ctl_fire  = bus_wr && (bus_addr == ADDR_CTL);

  crc_size_decode #(.NBYTES(NBYTES)) u_size (
    .size   (ctl_q.size),
    .nbytes (nbytes)
  );

  crc_fold #(
    .DATA_W      (DATA_W),
    .POLY_WIDE   (POLY_WIDE),
    .POLY_NARROW (POLY_NARROW)
  ) u_fold (
    .crc_in  (res_q),
    .data    (bus_wdata[DATA_W-1:0]),
    .narrow  (ctl_q.narrow),
    .nbytes  (nbytes),
    .crc_out (res_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
      res_q <= '0;
      ctl_q <= '{size: SZ_8, narrow: 1'b0};
    end else begin
      if (upd_fire) begin
        din_q <= bus_wdata;
        res_q <= res_next;
      end
      if (seed_fire) res_q <= bus_wdata;
      if (ctl_fire)  ctl_q <= ctl_t'(bus_wdata[2:0]);
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_DIN: bus_rdata = din_q;
      ADDR_RES: bus_rdata = ctl_q.narrow ? {16'd0, res_q[15:0]} : res_q;
      ADDR_CTL: bus_rdata = {29'd0, ctl_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_fire,
  input logic        seed_fire,
  input logic        ctl_fire,
  input logic        narrow,
  input logic [31:0] bus_wdata,
  input logic [31:0] din_q,
  input logic [31:0] res_q
);
  AST_DIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> din_q == $past(bus_wdata)); // R2

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seed_fire |=> res_q == $past(bus_wdata)); // R4

  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_fire || seed_fire) |=> $stable(res_q)); // R3

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && narrow) |=> res_q[31:16] == 16'd0); // R8

  AST_CTL_KEEPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire |=> res_q == $past(res_q)); // R10
endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_fire  (upd_fire),
  .seed_fire (seed_fire),
  .ctl_fire  (ctl_fire),
  .narrow    (ctl_q.narrow),
  .bus_wdata (bus_wdata),
  .din_q     (din_q),
  .res_q     (res_q)
);

// File: tb/sim_crc_engine.sv
module sim_crc_engine;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  crc_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Bit-serial reference: 'sz' is the size code, 'nar' the generator bit.
  function automatic logic [31:0] ref_step(input logic [31:0] st, input logic [31:0] d,
                                           input bit nar, input logic [1:0] sz);
    int nbits;
    logic [31:0] c32;
    logic [15:0] c16;
    logic fb;
    nbits = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    if (!nar) begin
      c32 = st;
      for (int j = 0; j < nbits; j++) begin
        fb  = c32[0] ^ d[j];
        c32 = c32 >> 1;
        if (fb) c32 = c32 ^ 32'hEDB88320;
      end
      return c32;
    end
    c16 = st[15:0];
    for (int by = 0; by < nbits/8; by++) begin
      for (int k = 7; k >= 0; k--) begin
        fb  = c16[15] ^ d[8*by + k];
        c16 = c16 << 1;
        if (fb) c16 = c16 ^ 16'h1021;
      end
    end
    return {16'd0, c16};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d got=%08h exp=%08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rng, seed, dat, exp;
    rng = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd_chk(2'd0, 32'h0, "R1");
    rd_chk(2'd1, 32'h0, "R1");
    rd_chk(2'd2, 32'h0, "R1");
    rd_chk(2'd3, 32'h0, "R1");

    // R9: check strings, no final inversion; R7 byte order via word writes
    wr(2'd2, 32'h0);                 // 32-bit generator, 8-bit size
    wr(2'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 9; i++) wr(2'd0, 32'hA5A5_A500 | (32'h31 + i));
    rd_chk(2'd1, 32'h340B_C6D9, "R9");
    wr(2'd2, 32'h4);                 // 32-bit size
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h3433_3231);
    wr(2'd0, 32'h3837_3635);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0000_0039);
    rd_chk(2'd1, 32'h340B_C6D9, "R7");
    wr(2'd2, 32'h5);                 // 16-bit generator, 32-bit size
    wr(2'd1, 32'h0000_FFFF);
    wr(2'd0, 32'h3433_3231);
    wr(2'd0, 32'h3837_3635);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'hFFFF_FF39);
    rd_chk(2'd1, 32'h0000_29B1, "R9");

    // R8: seed with upper bits set, read masked in 16-bit mode, visible in 32-bit
    wr(2'd1, 32'hDEAD_BEEF);
    rd_chk(2'd1, 32'h0000_BEEF, "R8");
    wr(2'd2, 32'h0);                 // R10: control write leaves result intact
    rd_chk(2'd1, 32'hDEAD_BEEF, "R10");
    rd_chk(2'd2, 32'h0, "R10");

    // Sweep: both generators x all four size codes (R5, R6, R3, R2, R4)
    for (int nar = 0; nar < 2; nar++) begin
      for (int sz = 0; sz < 4; sz++) begin
        wr(2'd2, {29'd0, 2'(sz), 1'(nar)});
        rd_chk(2'd2, {29'd0, 2'(sz), 1'(nar)}, "R5");
        for (int n = 0; n < 24; n++) begin
          rng = xs(rng); seed = rng;
          rng = xs(rng); dat = rng;
          wr(2'd1, seed);
          wr(2'd0, dat);
          exp = ref_step(seed, dat, nar[0], 2'(sz));
          rd_chk(2'd1, exp, (nar != 0) ? "R5/R6 narrow" : "R5/R6 wide");
          rd_chk(2'd0, dat, "R2");
          // R3: idle cycles change nothing
          @(negedge clk);
          rd_chk(2'd1, exp, "R3");
        end
      end
    end

    // R10/R4: chained stream with mid-stream generator and size changes
    wr(2'd1, 32'h0BAD_F00D);
    exp = 32'h0BAD_F00D;
    for (int n = 0; n < 40; n++) begin
      logic [2:0] cfg;
      rng = xs(rng); cfg = rng[2:0];
      wr(2'd2, {29'd0, cfg});
      rd_chk(2'd1, cfg[0] ? {16'd0, exp[15:0]} : exp, "R10");
      rng = xs(rng); dat = rng;
      wr(2'd0, dat);
      exp = ref_step(exp, dat, cfg[0], cfg[2:1]);
      rd_chk(2'd1, exp, "R4");
    end

    // R6: upper bytes ignored in 8-bit mode
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FF00);
    rd_chk(2'd1, 32'h0, "R6");

    finish_run();
  end
endmodule